// File: doc/BRIEF.md
# Guest Exit Condition Evaluator

This block sits beside a processor core that runs guest software under a monitor. Each cycle it looks at the guest events reported by the core and decides whether one of them must hand control back to the monitor. The events are an external interrupt arriving, the guest changing its interrupt-enable level, a guest write to the task-priority value, an exception with its vector, an I/O port access and a model-specific register (MSR) access with its direction. When an exit is due, the block raises a one-cycle exit pulse with a 3-bit reason code. It also keeps a shadow copy of the guest task-priority value, so that most priority writes can complete without an exit.

The monitor programs the filters through a single register write port. The filters are three control flags, a priority threshold, a 32-bit exception mask and three bitmaps. The bitmaps are one bit per I/O port over the full 16-bit port space, one read mask over 1024 MSR indices and one write mask over the same indices. The bitmaps live in internal synchronous RAMs, so every lookup takes the same two-edge path. When several events are presented in the same cycle, a fixed priority picks the single reason that is reported.

Top module: `exit_eval_top`

## Requirements
- R1: After reset, exit_o is 0, exit_reason_o is 0 and shadow_tpr_o is 0. All three control flags, the threshold and the exception mask are cleared, so an external interrupt or an exception causes no exit until they are programmed.
- R2: With external-interrupt exiting enabled, ext_irq_i causes an exit with reason 1 whatever the level of guest_ien_i. With the flag clear, ext_irq_i causes no exit.
- R3: With interrupt-window exiting enabled, a 0-to-1 change of guest_ien_i (guest unmasks interrupts) causes an exit with reason 2. Holding guest_ien_i high, or lowering it, causes no exit. With the flag clear, changes of guest_ien_i never cause an exit.
- R4: With shadowing enabled, a priority write loads tpr_data_i into shadow_tpr_o, and it exits with reason 3 only when the written value is strictly below the threshold. With shadowing disabled, every priority write exits with reason 3 and shadow_tpr_o keeps its value.
- R5: An exception with vector v (0 to 31) exits with reason 4 exactly when bit v of the exception mask is set.
- R6: An I/O access to port p exits with reason 5 exactly when bit p[4:0] of I/O bitmap word p[15:5] is set.
- R7: An MSR access to index n below 1024 checks bit n[4:0] of word n[9:5]. A read (msr_write_i=0) checks the read mask and exits with reason 6. A write checks the write mask and exits with reason 7.
- R8: An MSR access with index 1024 or above always exits, with reason 6 for a read and 7 for a write.
- R9: When several events hit in one cycle, the reported reason follows the priority external interrupt, exception, I/O, MSR, priority threshold, interrupt window.
- R10: An event sampled at clock edge k gives exit_o high for exactly the cycle after edge k+1. exit_reason_o is 0 whenever exit_o is 0.
- R11: A configuration write takes effect for events sampled from the next edge. The address map is as follows. Address bit 12 set selects I/O bitmap word addr[10:0]. Otherwise, addr[11:10]=01 selects MSR read-mask word addr[4:0] and addr[11:10]=10 selects MSR write-mask word addr[4:0]. With addr[11:10]=00, offset 0 holds the flags (bit 0 external-interrupt exiting, bit 1 interrupt-window exiting, bit 2 shadowing enable), offset 1 holds the threshold in bits 7:0 and offset 2 holds the exception mask.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_addr_i | input | 13 | Configuration word address |
| cfg_wdata_i | input | 32 | Configuration write data |
| ext_irq_i | input | 1 | External interrupt arrives this cycle |
| guest_ien_i | input | 1 | Guest interrupt-enable level (1 = unmasked) |
| tpr_wr_i | input | 1 | Guest writes the task-priority value |
| tpr_data_i | input | 8 | Value written by the guest |
| exc_valid_i | input | 1 | Guest raises an exception |
| exc_vec_i | input | 5 | Exception vector |
| io_valid_i | input | 1 | Guest accesses an I/O port |
| io_port_i | input | 16 | Accessed port number |
| msr_valid_i | input | 1 | Guest accesses an MSR |
| msr_write_i | input | 1 | MSR access direction (1 = write) |
| msr_idx_i | input | 16 | MSR index |
| exit_o | output | 1 | Exit request pulse |
| exit_reason_o | output | 3 | Reason code, 0 when no exit |
| shadow_tpr_o | output | 8 | Shadow task-priority value |

## Verification
A wrong bitmap word or mask bit shows up as a missing or extra exit pulse exactly two edges after the event that reads it. A stale interrupt-enable history shows up as a spurious or missing reason-2 exit on the next unmask. A corrupted shadow register shows on shadow_tpr_o one edge after the priority write that should have loaded it, or as a change where none was due. A priority error appears only when events collide, so the stimulus deliberately stacks several hitting events in one cycle and reads the single reason code that wins.

// File: rtl/exit_eval_pkg.sv
// Package: shared types of the guest exit condition evaluator.
// Assumes: reason codes are fixed by the host software contract.
package exit_eval_pkg;

    // Encoded exit reasons; 0 means no exit this cycle.
    typedef enum logic [2:0] {
        RSN_NONE   = 3'd0,
        RSN_EXT    = 3'd1,
        RSN_WIN    = 3'd2,
        RSN_TPR    = 3'd3,
        RSN_EXC    = 3'd4,
        RSN_IO     = 3'd5,
        RSN_MSR_RD = 3'd6,
        RSN_MSR_WR = 3'd7
    } exit_reason_e;

    // Per-filter hit flags presented to the priority stage.
    typedef struct packed {
        logic ext;
        logic exc;
        logic io;
        logic msr;
        logic msr_wr;
        logic tpr;
        logic win;
    } exit_hits_t;

endpackage

// File: rtl/exit_cfg_regs.sv
// Module: exit_cfg_regs
// Holds the execution-control registers and decodes the host write port
// into register loads and bitmap RAM write strobes.
// Assumes: one write per cycle; writes to unused control offsets are dropped.
module exit_cfg_regs #(
    parameter int WORD_W     = 32,
    parameter int TPR_W      = 8,
    parameter int EXC_N      = 32,
    parameter int IO_WADDR_W = 11,
    localparam int CFG_ADDR_W = IO_WADDR_W + 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  cfg_we_i,
    input  logic [CFG_ADDR_W-1:0] cfg_addr_i,
    input  logic [WORD_W-1:0]     cfg_wdata_i,
    output logic                  ctl_ext_o,
    output logic                  ctl_win_o,
    output logic                  ctl_shadow_o,
    output logic [TPR_W-1:0]      tpr_thresh_o,
    output logic [EXC_N-1:0]      exc_mask_o,
    output logic                  io_we_o,
    output logic                  msr_rd_we_o,
    output logic                  msr_wr_we_o,
    output logic [IO_WADDR_W-1:0] word_addr_o
);

    localparam logic [1:0] REGION_CTRL = 2'b00;
    localparam logic [1:0] REGION_MRD  = 2'b01;
    localparam logic [1:0] REGION_MWR  = 2'b10;

    logic       is_io;
    logic [1:0] region;
    logic       ctrl_we;

    // Split the address into bitmap select, region and word offset.
    always_comb begin
        is_io       = cfg_addr_i[CFG_ADDR_W-1];
        region      = cfg_addr_i[IO_WADDR_W -: 2];
        word_addr_o = cfg_addr_i[IO_WADDR_W-1:0];
        io_we_o     = cfg_we_i && is_io;
        msr_rd_we_o = cfg_we_i && !is_io && (region == REGION_MRD);
        msr_wr_we_o = cfg_we_i && !is_io && (region == REGION_MWR);
        ctrl_we     = cfg_we_i && !is_io && (region == REGION_CTRL);
    end

    // Load the control flags, threshold and exception mask.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_ext_o    <= 1'b0;
            ctl_win_o    <= 1'b0;
            ctl_shadow_o <= 1'b0;
            tpr_thresh_o <= '0;
            exc_mask_o   <= '0;
        end else if (ctrl_we) begin
            case (cfg_addr_i[1:0])
                2'd0: begin
                    ctl_ext_o    <= cfg_wdata_i[0];
                    ctl_win_o    <= cfg_wdata_i[1];
                    ctl_shadow_o <= cfg_wdata_i[2];
                end
                2'd1:    tpr_thresh_o <= cfg_wdata_i[TPR_W-1:0];
                2'd2:    exc_mask_o   <= cfg_wdata_i[EXC_N-1:0];
                default: ;
            endcase
        end
    end

    assert_flags_write_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we_i && cfg_addr_i == '0) |=> (ctl_ext_o == $past(cfg_wdata_i[0])))
        else $error("flag write not applied");

    assert_thresh_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_we_i |=> $stable(tpr_thresh_o))
        else $error("threshold changed without a write");

endmodule

// File: rtl/exit_bitmap_ram.sv
// Module: exit_bitmap_ram
// Word-wide bitmap storage with one write port and one registered read port.
// Assumes: a read and a write of the same word in one cycle return the old word;
// contents are undefined until written by the host.
module exit_bitmap_ram #(
    parameter int WORDS  = 2048,
    parameter int WORD_W = 32,
    localparam int AW    = $clog2(WORDS)
) (
    input  logic              clk,
    input  logic              we_i,
    input  logic [AW-1:0]     waddr_i,
    input  logic [WORD_W-1:0] wdata_i,
    input  logic [AW-1:0]     raddr_i,
    output logic [WORD_W-1:0] rdata_o
);

    logic [WORD_W-1:0] mem [WORDS];

    // Store host writes and fetch the word addressed by the current event.
    always_ff @(posedge clk) begin
        if (we_i) begin
            mem[waddr_i] <= wdata_i;
        end
        rdata_o <= mem[raddr_i];
    end

endmodule

// File: rtl/exit_prio_enc.sv
// Module: exit_prio_enc
// Picks one reason from the per-filter hits by fixed priority and registers
// the exit pulse and its code.
// Assumes: hits are valid for one cycle only.
module exit_prio_enc
    import exit_eval_pkg::*;
(
    input  logic         clk,
    input  logic         rst_n,
    input  exit_hits_t   hits_i,
    output logic         exit_o,
    output exit_reason_e reason_o
);

    exit_reason_e pick;

    // Fixed priority: ext, exception, I/O, MSR, threshold, window.
    always_comb begin
        if (hits_i.ext)       pick = RSN_EXT;
        else if (hits_i.exc)  pick = RSN_EXC;
        else if (hits_i.io)   pick = RSN_IO;
        else if (hits_i.msr)  pick = hits_i.msr_wr ? RSN_MSR_WR : RSN_MSR_RD;
        else if (hits_i.tpr)  pick = RSN_TPR;
        else if (hits_i.win)  pick = RSN_WIN;
        else                  pick = RSN_NONE;
    end

    // Register the decision so the outputs are glitch-free pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            exit_o   <= 1'b0;
            reason_o <= RSN_NONE;
        end else begin
            exit_o   <= (pick != RSN_NONE);
            reason_o <= pick;
        end
    end

    assert_quiet_code_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !exit_o |-> (reason_o == RSN_NONE))
        else $error("reason code without exit");

endmodule

// File: rtl/exit_eval_top.sv
// Module: exit_eval_top
// Guest exit condition evaluator. Stage 1 registers the per-event filter
// results and the bitmap RAM words; stage 2 picks the reason and registers it.
// Assumes: every event input is a single-cycle strobe except guest_ien_i,
// which is a level; the MSR count and port space are multiples of WORD_W.
module exit_eval_top
    import exit_eval_pkg::*;
#(
    parameter int WORD_W    = 32,
    parameter int TPR_W     = 8,
    parameter int EXC_N     = 32,
    parameter int IO_PORT_W = 16,
    parameter int MSR_IDX_W = 16,
    parameter int MSR_COUNT = 1024,
    localparam int BIT_W      = $clog2(WORD_W),
    localparam int IO_WORDS   = (2 ** IO_PORT_W) / WORD_W,
    localparam int IO_WADDR_W = $clog2(IO_WORDS),
    localparam int MSR_WORDS  = MSR_COUNT / WORD_W,
    localparam int MSR_AW     = $clog2(MSR_WORDS),
    localparam int MSR_RNG_W  = $clog2(MSR_COUNT),
    localparam int EXC_W      = $clog2(EXC_N),
    localparam int CFG_ADDR_W = IO_WADDR_W + 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  cfg_we_i,
    input  logic [CFG_ADDR_W-1:0] cfg_addr_i,
    input  logic [WORD_W-1:0]     cfg_wdata_i,
    input  logic                  ext_irq_i,
    input  logic                  guest_ien_i,
    input  logic                  tpr_wr_i,
    input  logic [TPR_W-1:0]      tpr_data_i,
    input  logic                  exc_valid_i,
    input  logic [EXC_W-1:0]      exc_vec_i,
    input  logic                  io_valid_i,
    input  logic [IO_PORT_W-1:0]  io_port_i,
    input  logic                  msr_valid_i,
    input  logic                  msr_write_i,
    input  logic [MSR_IDX_W-1:0]  msr_idx_i,
    output logic                  exit_o,
    output logic [2:0]            exit_reason_o,
    output logic [TPR_W-1:0]      shadow_tpr_o
);

    localparam logic [MSR_IDX_W-1:0] MSR_LIMIT = MSR_IDX_W'(MSR_COUNT);

    // Control register outputs and decoded write strobes.
    logic                  ctl_ext, ctl_win, ctl_shadow;
    logic [TPR_W-1:0]      tpr_thresh;
    logic [EXC_N-1:0]      exc_mask;
    logic                  io_we;
    logic [1:0]            msr_we;
    logic [IO_WADDR_W-1:0] word_addr;

    exit_cfg_regs #(
        .WORD_W     (WORD_W),
        .TPR_W      (TPR_W),
        .EXC_N      (EXC_N),
        .IO_WADDR_W (IO_WADDR_W)
    ) i_cfg (
        .clk          (clk),
        .rst_n        (rst_n),
        .cfg_we_i     (cfg_we_i),
        .cfg_addr_i   (cfg_addr_i),
        .cfg_wdata_i  (cfg_wdata_i),
        .ctl_ext_o    (ctl_ext),
        .ctl_win_o    (ctl_win),
        .ctl_shadow_o (ctl_shadow),
        .tpr_thresh_o (tpr_thresh),
        .exc_mask_o   (exc_mask),
        .io_we_o      (io_we),
        .msr_rd_we_o  (msr_we[0]),
        .msr_wr_we_o  (msr_we[1]),
        .word_addr_o  (word_addr)
    );

    // I/O bitmap: one bit per port, word = upper port bits.
    logic [WORD_W-1:0] io_word;

    exit_bitmap_ram #(
        .WORDS  (IO_WORDS),
        .WORD_W (WORD_W)
    ) i_io_map (
        .clk     (clk),
        .we_i    (io_we),
        .waddr_i (word_addr),
        .wdata_i (cfg_wdata_i),
        .raddr_i (io_port_i[IO_PORT_W-1:BIT_W]),
        .rdata_o (io_word)
    );

    // MSR masks: index 0 is the read mask, index 1 the write mask.
    logic [WORD_W-1:0] msr_word [2];

    for (genvar d = 0; d < 2; d++) begin : g_msr_map
        exit_bitmap_ram #(
            .WORDS  (MSR_WORDS),
            .WORD_W (WORD_W)
        ) i_msr_map (
            .clk     (clk),
            .we_i    (msr_we[d]),
            .waddr_i (word_addr[MSR_AW-1:0]),
            .wdata_i (cfg_wdata_i),
            .raddr_i (msr_idx_i[MSR_RNG_W-1:BIT_W]),
            .rdata_o (msr_word[d])
        );
    end

    // Stage 1 state.
    logic             ien_prev;
    logic             s1_ext, s1_win, s1_tpr, s1_exc;
    logic             s1_io_v, s1_msr_v, s1_msr_wr, s1_msr_oor;
    logic [BIT_W-1:0] s1_io_bit, s1_msr_bit;
    logic [TPR_W-1:0] shadow_q;

    // Evaluate the register-only filters and remember bit selects for the RAMs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ien_prev   <= 1'b0;
            s1_ext     <= 1'b0;
            s1_win     <= 1'b0;
            s1_tpr     <= 1'b0;
            s1_exc     <= 1'b0;
            s1_io_v    <= 1'b0;
            s1_msr_v   <= 1'b0;
            s1_msr_wr  <= 1'b0;
            s1_msr_oor <= 1'b0;
            s1_io_bit  <= '0;
            s1_msr_bit <= '0;
        end else begin
            ien_prev   <= guest_ien_i;
            s1_ext     <= ext_irq_i && ctl_ext;
            s1_win     <= guest_ien_i && !ien_prev && ctl_win;
            s1_tpr     <= tpr_wr_i && (!ctl_shadow || (tpr_data_i < tpr_thresh));
            s1_exc     <= exc_valid_i && exc_mask[exc_vec_i];
            s1_io_v    <= io_valid_i;
            s1_io_bit  <= io_port_i[BIT_W-1:0];
            s1_msr_v   <= msr_valid_i;
            s1_msr_wr  <= msr_write_i;
            s1_msr_oor <= (msr_idx_i >= MSR_LIMIT);
            s1_msr_bit <= msr_idx_i[BIT_W-1:0];
        end
    end

    // Keep the shadow priority value for guest writes while shadowing is on.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shadow_q <= '0;
        end else if (tpr_wr_i && ctl_shadow) begin
            shadow_q <= tpr_data_i;
        end
    end

    assign shadow_tpr_o = shadow_q;

    // Finish the RAM-backed filters and gather all hits for the priority stage.
    exit_hits_t        hits;
    logic [WORD_W-1:0] msr_sel_word;

    always_comb begin
        msr_sel_word = s1_msr_wr ? msr_word[1] : msr_word[0];
        hits.ext     = s1_ext;
        hits.exc     = s1_exc;
        hits.io      = s1_io_v && io_word[s1_io_bit];
        hits.msr     = s1_msr_v && (s1_msr_oor || msr_sel_word[s1_msr_bit]);
        hits.msr_wr  = s1_msr_wr;
        hits.tpr     = s1_tpr;
        hits.win     = s1_win;
    end

    exit_reason_e reason;

    exit_prio_enc i_prio (
        .clk      (clk),
        .rst_n    (rst_n),
        .hits_i   (hits),
        .exit_o   (exit_o),
        .reason_o (reason)
    );

    assign exit_reason_o = reason;

    // Checks on the two-stage path.
    logic s1_any;
    assign s1_any = s1_ext || s1_win || s1_tpr || s1_exc || s1_io_v || s1_msr_v;

    assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !s1_any |=> (!exit_o && exit_reason_o == 3'd0))
        else $error("exit without a candidate event");

    assert_ext_first_R9: assert property (@(posedge clk) disable iff (!rst_n)
        s1_ext |=> (exit_o && exit_reason_o == 3'd1))
        else $error("external interrupt not reported first");

    assert_ext_exit_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (ext_irq_i && ctl_ext) |=> ##1 (exit_o && exit_reason_o == 3'd1))
        else $error("external interrupt exit missing");

    assert_exc_exit_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (exc_valid_i && exc_mask[exc_vec_i]) |=> ##1 exit_o)
        else $error("masked exception did not exit");

    assert_msr_range_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (s1_msr_v && s1_msr_oor) |=> exit_o)
        else $error("out-of-range MSR access did not exit");

    assert_shadow_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (tpr_wr_i && ctl_shadow) |=> (shadow_tpr_o == $past(tpr_data_i)))
        else $error("shadow not loaded");

    assert_shadow_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !(tpr_wr_i && ctl_shadow) |=> $stable(shadow_tpr_o))
        else $error("shadow changed without a shadowed write");

endmodule

// File: tb/test_exit_eval_top.sv
// Bench for exit_eval_top: a vector table walked by one loop, then directed
// tests for reset, pulse timing, disabled filters and reprogramming.
module test_exit_eval_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [12:0] cfg_addr = '0;
    logic [31:0] cfg_wdata = '0;
    logic        ext_irq = 1'b0, guest_ien = 1'b0, tpr_wr = 1'b0;
    logic [7:0]  tpr_data = '0;
    logic        exc_valid = 1'b0;
    logic [4:0]  exc_vec = '0;
    logic        io_valid = 1'b0;
    logic [15:0] io_port = '0;
    logic        msr_valid = 1'b0, msr_write = 1'b0;
    logic [15:0] msr_idx = '0;
    logic        exit_o;
    logic [2:0]  exit_reason;
    logic [7:0]  shadow_tpr;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    exit_eval_top i_exit_eval_top (
        .clk           (clk),
        .rst_n         (rst_n),
        .cfg_we_i      (cfg_we),
        .cfg_addr_i    (cfg_addr),
        .cfg_wdata_i   (cfg_wdata),
        .ext_irq_i     (ext_irq),
        .guest_ien_i   (guest_ien),
        .tpr_wr_i      (tpr_wr),
        .tpr_data_i    (tpr_data),
        .exc_valid_i   (exc_valid),
        .exc_vec_i     (exc_vec),
        .io_valid_i    (io_valid),
        .io_port_i     (io_port),
        .msr_valid_i   (msr_valid),
        .msr_write_i   (msr_write),
        .msr_idx_i     (msr_idx),
        .exit_o        (exit_o),
        .exit_reason_o (exit_reason),
        .shadow_tpr_o  (shadow_tpr)
    );

    typedef struct packed {
        logic        ext;
        logic        ien;
        logic        tw;
        logic [7:0]  tv;
        logic        ev;
        logic [4:0]  vec;
        logic        iov;
        logic [15:0] port;
        logic        mv;
        logic        mw;
        logic [15:0] idx;
        logic        x_exit;
        logic [2:0]  x_rsn;
    } vec_t;

    localparam int NV = 23;
    // Setup before the table: flags=7, threshold=0x40, exception mask bits 3 and 14,
    // I/O ports 0x0060 and 0x03F8 set, MSR read 0x10 set, MSR write 0x22 set.
    localparam vec_t VT [NV] = '{
        '{1'b1,1'b0,1'b0,8'h00,1'b0,5'd0, 1'b0,16'h0000,1'b0,1'b0,16'h0000,1'b1,3'd1}, // R2 masked guest
        '{1'b1,1'b1,1'b0,8'h00,1'b0,5'd0, 1'b0,16'h0000,1'b0,1'b0,16'h0000,1'b1,3'd1}, // R9 ext over window
        '{1'b0,1'b1,1'b0,8'h00,1'b0,5'd0, 1'b0,16'h0000,1'b0,1'b0,16'h0000,1'b0,3'd0}, // R3 held high
        '{1'b0,1'b0,1'b0,8'h00,1'b0,5'd0, 1'b0,16'h0000,1'b0,1'b0,16'h0000,1'b0,3'd0}, // R3 mask
        '{1'b0,1'b1,1'b0,8'h00,1'b0,5'd0, 1'b0,16'h0000,1'b0,1'b0,16'h0000,1'b1,3'd2}, // R3 unmask
        '{1'b0,1'b1,1'b1,8'h50,1'b0,5'd0, 1'b0,16'h0000,1'b0,1'b0,16'h0000,1'b0,3'd0}, // R4 above
        '{1'b0,1'b1,1'b1,8'h3F,1'b0,5'd0, 1'b0,16'h0000,1'b0,1'b0,16'h0000,1'b1,3'd3}, // R4 below
        '{1'b0,1'b1,1'b1,8'h40,1'b0,5'd0, 1'b0,16'h0000,1'b0,1'b0,16'h0000,1'b0,3'd0}, // R4 equal
        '{1'b0,1'b1,1'b0,8'h00,1'b1,5'd14,1'b0,16'h0000,1'b0,1'b0,16'h0000,1'b1,3'd4}, // R5 set
        '{1'b0,1'b1,1'b0,8'h00,1'b1,5'd13,1'b0,16'h0000,1'b0,1'b0,16'h0000,1'b0,3'd0}, // R5 clear
        '{1'b0,1'b1,1'b0,8'h00,1'b0,5'd0, 1'b1,16'h0060,1'b0,1'b0,16'h0000,1'b1,3'd5}, // R6 set
        '{1'b0,1'b1,1'b0,8'h00,1'b0,5'd0, 1'b1,16'h0061,1'b0,1'b0,16'h0000,1'b0,3'd0}, // R6 neighbour
        '{1'b0,1'b1,1'b0,8'h00,1'b0,5'd0, 1'b1,16'h03F8,1'b0,1'b0,16'h0000,1'b1,3'd5}, // R6 high bit
        '{1'b0,1'b1,1'b0,8'h00,1'b0,5'd0, 1'b0,16'h0000,1'b1,1'b0,16'h0010,1'b1,3'd6}, // R7 read set
        '{1'b0,1'b1,1'b0,8'h00,1'b0,5'd0, 1'b0,16'h0000,1'b1,1'b1,16'h0010,1'b0,3'd0}, // R7 write clear
        '{1'b0,1'b1,1'b0,8'h00,1'b0,5'd0, 1'b0,16'h0000,1'b1,1'b1,16'h0022,1'b1,3'd7}, // R7 write set
        '{1'b0,1'b1,1'b0,8'h00,1'b0,5'd0, 1'b0,16'h0000,1'b1,1'b0,16'h0022,1'b0,3'd0}, // R7 read clear
        '{1'b0,1'b1,1'b0,8'h00,1'b0,5'd0, 1'b0,16'h0000,1'b1,1'b0,16'h0400,1'b1,3'd6}, // R8 read edge
        '{1'b0,1'b1,1'b0,8'h00,1'b0,5'd0, 1'b0,16'h0000,1'b1,1'b1,16'hFFFF,1'b1,3'd7}, // R8 write top
        '{1'b0,1'b1,1'b1,8'h10,1'b1,5'd14,1'b1,16'h0060,1'b1,1'b0,16'h0010,1'b1,3'd4}, // R9 exc first
        '{1'b0,1'b1,1'b1,8'h10,1'b0,5'd0, 1'b1,16'h0060,1'b1,1'b1,16'h0022,1'b1,3'd5}, // R9 io over msr
        '{1'b0,1'b0,1'b1,8'h10,1'b0,5'd0, 1'b0,16'h0000,1'b1,1'b1,16'h0022,1'b1,3'd7}, // R9 msr over tpr
        '{1'b0,1'b1,1'b1,8'h10,1'b0,5'd0, 1'b0,16'h0000,1'b0,1'b0,16'h0000,1'b1,3'd3}  // R9 tpr over window
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic cfg_write(input logic [12:0] a, input logic [31:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(posedge clk);
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    // Present one vector for one edge, idle for one edge, sample after the second.
    task automatic run_vec(input vec_t v);
        @(negedge clk);
        ext_irq = v.ext; guest_ien = v.ien; tpr_wr = v.tw; tpr_data = v.tv;
        exc_valid = v.ev; exc_vec = v.vec; io_valid = v.iov; io_port = v.port;
        msr_valid = v.mv; msr_write = v.mw; msr_idx = v.idx;
        @(posedge clk);
        @(negedge clk);
        ext_irq = 1'b0; tpr_wr = 1'b0; exc_valid = 1'b0; io_valid = 1'b0; msr_valid = 1'b0;
        @(posedge clk);
        #1;
    endtask

    function automatic vec_t ev0(input logic ien);
        vec_t v = '0;
        v.ien = ien;
        return v;
    endfunction

    task automatic summary;
        $display("Result: errors=%0d of %0d checks", errors, checks);
    endtask

    initial begin
        vec_t v;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1 reset state
        chk("R1 exit after reset", 32'(exit_o), 32'd0);
        chk("R1 reason after reset", 32'(exit_reason), 32'd0);
        chk("R1 shadow after reset", 32'(shadow_tpr), 32'd0);
        // R1 cleared filters: ext interrupt and exception do not exit
        v = ev0(1'b0); v.ext = 1'b1; v.ev = 1'b1; v.vec = 5'd0;
        run_vec(v);
        chk("R1 cleared filters exit", 32'(exit_o), 32'd0);
        // R1/R4 shadow off after reset: priority write exits, shadow untouched
        v = ev0(1'b0); v.tw = 1'b1; v.tv = 8'h05;
        run_vec(v);
        chk("R4 unshadowed write reason", 32'(exit_reason), 32'd3);
        chk("R4 unshadowed write shadow", 32'(shadow_tpr), 32'd0);

        // R11 program the filters
        cfg_write(13'h0000, 32'h7);
        cfg_write(13'h0001, 32'h40);
        cfg_write(13'h0002, 32'h0000_4008);
        cfg_write(13'h1003, 32'h0000_0001);
        cfg_write(13'h101F, 32'h0100_0000);
        cfg_write(13'h0400, 32'h0001_0000);
        cfg_write(13'h0401, 32'h0000_0000);
        cfg_write(13'h0800, 32'h0000_0000);
        cfg_write(13'h0801, 32'h0000_0004);

        for (int i = 0; i < NV; i++) begin
            run_vec(VT[i]);
            chk($sformatf("vector %0d exit (R2..R9)", i), 32'(exit_o), 32'(VT[i].x_exit));
            chk($sformatf("vector %0d reason (R2..R9)", i), 32'(exit_reason), 32'(VT[i].x_rsn));
        end
        chk("R4 shadow holds last shadowed write", 32'(shadow_tpr), 32'h10);

        // R10 pulse timing: silent after first edge, high after second, low after third
        @(negedge clk);
        ext_irq = 1'b1;
        @(posedge clk); #1;
        chk("R10 no exit after first edge", 32'(exit_o), 32'd0);
        @(negedge clk);
        ext_irq = 1'b0;
        @(posedge clk); #1;
        chk("R10 exit after second edge", 32'(exit_o), 32'd1);
        @(posedge clk); #1;
        chk("R10 single-cycle pulse", 32'(exit_o), 32'd0);
        chk("R10 reason cleared", 32'(exit_reason), 32'd0);

        // R4 shadowing disabled: write exits and shadow keeps 0x10
        cfg_write(13'h0000, 32'h3);
        v = ev0(1'b1); v.tw = 1'b1; v.tv = 8'h80;
        run_vec(v);
        chk("R4 shadow off exit reason", 32'(exit_reason), 32'd3);
        chk("R4 shadow off keeps value", 32'(shadow_tpr), 32'h10);

        // R2/R3 flags clear: interrupt and unmask do not exit
        cfg_write(13'h0000, 32'h0);
        run_vec(ev0(1'b0));
        v = ev0(1'b1); v.ext = 1'b1;
        run_vec(v);
        chk("R2 R3 disabled filters exit", 32'(exit_o), 32'd0);

        // R11 exception mask rewrite takes effect on the next event
        cfg_write(13'h0002, 32'h8000_0000);
        v = ev0(1'b1); v.ev = 1'b1; v.vec = 5'd31;
        run_vec(v);
        chk("R11 R5 vector 31 after rewrite", 32'(exit_reason), 32'd4);
        v.vec = 5'd14;
        run_vec(v);
        chk("R11 R5 vector 14 after rewrite", 32'(exit_o), 32'd0);

        // R6 cleared I/O word: rewrite word 3 to zero, port 0x60 no longer exits
        cfg_write(13'h1003, 32'h0);
        v = ev0(1'b1); v.iov = 1'b1; v.port = 16'h0060;
        run_vec(v);
        chk("R6 cleared port", 32'(exit_o), 32'd0);

        done = 1'b1;
        summary();
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog R10: actual=hung expected=finished");
            summary();
            $finish;
        end
    end

endmodule